// File: doc/BRIEF.md
# Serial CRC-8 Generator and Checker

This block produces the 8-bit checksum that is appended to short register-bus datagrams. Bytes arrive over a valid/ready handshake. Each byte is absorbed one bit per clock, starting at bit 0. The checksum register shifts left, and it folds in the generator x^8 + x^2 + x + 1 whenever the bit leaving the top differs from the incoming data bit. The register starts from zero at every frame, and the result is output as it stands, with no reflection and no final inversion.

A frame ends on an end marker that travels with a byte, or after a fixed count of 3 bytes (a read request) or 7 bytes (a write). At the end of a frame the checksum is presented with a one-cycle strobe. In check mode, the byte that follows the frame is taken as the received checksum. It is compared with the computed value instead of being absorbed, and a match result is reported.

Top module: `crc8_serial_gen`

## Requirements
- R1: For every byte, bits 0 through 7 are taken in that order. For each bit, the register shifts left one place and is XORed with 0x07 when its old bit 7 XOR the data bit is 1.
- R2: After reset, crc_out is 0x00. The register restarts from 0x00 on a byte accepted with in_sof high, and on the first byte accepted after a frame has ended.
- R3: in_ready is high while idle. After a byte is accepted, in_ready is low for the next 7 cycles, so one byte takes 8 cycles.
- R4: With len_mode 2'b00 or 2'b11, a frame ends with the byte accepted while in_eof is high.
- R5: crc_valid is a single-cycle pulse. It comes in the eighth cycle after the last byte of a frame is accepted, and in that cycle crc_out holds the frame's checksum.
- R6: With len_mode 2'b01, a frame ends after its third byte, and in_eof has no effect.
- R7: With len_mode 2'b10, a frame ends after its seventh byte, and in_eof has no effect.
- R8: If chk_en is high on a frame's last byte, the next accepted byte is not absorbed. One cycle after it is accepted, chk_valid pulses, with chk_match set exactly when that byte equals the checksum. crc_out holds its value until then.
- R9: The first byte of the next frame is accepted in the same cycle as crc_valid, and the strobed checksum is not disturbed.
- R10: A frame whose bytes are all 0x00 yields 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted |
| in_data | input | 8 | Byte value |
| in_sof | input | 1 | Byte starts a new frame |
| in_eof | input | 1 | Byte ends the frame (marker mode) |
| len_mode | input | 2 | 00/11 marker, 01 three bytes, 10 seven bytes |
| chk_en | input | 1 | Compare the byte after this frame |
| crc_valid | output | 1 | Checksum strobe |
| crc_out | output | 8 | Checksum register |
| chk_valid | output | 1 | Compare result strobe |
| chk_match | output | 1 | Received byte equals checksum |

## Verification
Two events can fall in the same cycle: the end-of-frame strobe of one frame, and the acceptance of the next frame's first byte, which clears the register. The same overlap arises when the comparison byte is accepted under the strobe. The bench provokes both by driving frames back to back, with in_valid held high as the last bit finishes. A queue-based model, updated at every rising edge, predicts in_ready, the strobes and the checksum. Every cycle, the bench checks that the strobed value belongs to the finished frame and that the following frame still restarts from zero.

// File: rtl/crc8_serial_gen.sv
module crc8_serial_gen #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [1:0] len_mode,
  input  logic       chk_en,
  output logic       crc_valid,
  output logic [7:0] crc_out,
  output logic       chk_valid,
  output logic       chk_match
);

  function automatic logic [7:0] step(input logic [7:0] c, input logic b);
    return (c[7] ^ b) ? ({c[6:0], 1'b0} ^ POLY) : {c[6:0], 1'b0};
  endfunction

  logic [7:0] crc, sh;
  logic [2:0] bcnt, idx;
  logic       last_q, chk_q, fresh, cmp_pend;

  wire       acc      = in_valid && in_ready;
  wire       clr      = in_sof || fresh;
  wire [2:0] idx_base = clr ? 3'd0 : idx;
  wire       is_last  = (len_mode == 2'b01) ? (idx_base == 3'd2) :
                        (len_mode == 2'b10) ? (idx_base == 3'd6) : in_eof;

  assign in_ready = (bcnt == 3'd0);
  assign crc_out  = crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc       <= 8'h00;
      sh        <= 8'h00;
      bcnt      <= 3'd0;
      idx       <= 3'd0;
      last_q    <= 1'b0;
      chk_q     <= 1'b0;
      fresh     <= 1'b1;
      cmp_pend  <= 1'b0;
      crc_valid <= 1'b0;
      chk_valid <= 1'b0;
      chk_match <= 1'b0;
    end else begin
      crc_valid <= 1'b0;
      chk_valid <= 1'b0;
      if (acc && cmp_pend) begin
        chk_valid <= 1'b1;
        chk_match <= (in_data == crc);
        cmp_pend  <= 1'b0;
      end else if (acc) begin
        crc    <= step(clr ? 8'h00 : crc, in_data[0]);
        sh     <= {1'b0, in_data[7:1]};
        bcnt   <= 3'd7;
        last_q <= is_last;
        chk_q  <= chk_en;
        idx    <= is_last ? 3'd0 : idx_base + 3'd1;
        fresh  <= 1'b0;
      end else if (bcnt != 3'd0) begin
        crc  <= step(crc, sh[0]);
        sh   <= {1'b0, sh[7:1]};
        bcnt <= bcnt - 3'd1;
        if (bcnt == 3'd1 && last_q) begin
          crc_valid <= 1'b1;
          cmp_pend  <= chk_q;
          fresh     <= 1'b1;
        end
      end
    end
  end

endmodule

module crc8_serial_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic [7:0] in_data,
  input logic       crc_valid,
  input logic [7:0] crc_out,
  input logic       chk_valid,
  input logic       cmp_pend
);
  wire acc = in_valid && in_ready;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmp_pend |=> !in_ready); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |=> !crc_valid); // R5
  AST_STROBE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> in_ready); // R9
  AST_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_sof && !cmp_pend |=> crc_out == ($past(in_data[0]) ? 8'h07 : 8'h00)); // R2
  AST_HOLD_FOR_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pend && !acc |=> $stable(crc_out)); // R8
  AST_COMPARE_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(cmp_pend)); // R8
endmodule

bind crc8_serial_gen crc8_serial_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_data(in_data), .crc_valid(crc_valid),
  .crc_out(crc_out), .chk_valid(chk_valid), .cmp_pend(cmp_pend)
);

// File: tb/crc8_serial_gen_tb.sv
`timescale 1ns/1ps
module crc8_serial_gen_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, chk_en = 0;
  logic [7:0] in_data = 0;
  logic [1:0] len_mode = 0;
  logic in_ready, crc_valid, chk_valid, chk_match;
  logic [7:0] crc_out;

  always #2.5 clk = ~clk;

  crc8_serial_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .len_mode(len_mode),
    .chk_en(chk_en), .crc_valid(crc_valid), .crc_out(crc_out),
    .chk_valid(chk_valid), .chk_match(chk_match)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "reset";

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual %0h expected %0h", req, phase, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] frame[$];
  int m_busy = 0;
  bit m_fresh = 1, m_cmp = 0, m_last = 0, m_chk = 0, m_cv = 0, m_kv = 0, m_km = 0;
  logic [7:0] m_crc = 0;

  function automatic logic [7:0] ref_crc();
    logic [7:0] c;
    c = 8'h00;
    foreach (frame[i])
      for (int j = 0; j < 8; j++) begin
        if (c[7] ^ frame[i][j]) c = (c << 1) ^ 8'h07;
        else c = c << 1;
      end
    return c;
  endfunction

  always @(posedge clk) begin
    m_cv = 0; m_kv = 0;
    if (!rst_n) begin
      m_busy = 0; m_fresh = 1; m_cmp = 0; m_last = 0; m_chk = 0; m_crc = 0;
      frame.delete();
    end else if (m_busy == 0 && in_valid) begin
      if (m_cmp) begin
        m_kv = 1; m_km = (in_data == m_crc); m_cmp = 0;
      end else begin
        if (in_sof || m_fresh) frame.delete();
        frame.push_back(in_data);
        m_fresh = 0;
        case (len_mode)
          2'b01:   m_last = (frame.size() == 3);
          2'b10:   m_last = (frame.size() == 7);
          default: m_last = in_eof;
        endcase
        m_chk = chk_en;
        m_busy = 7;
      end
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0 && m_last) begin
        m_crc = ref_crc(); m_cv = 1; m_cmp = m_chk; m_fresh = 1;
      end
    end
  end

  logic [7:0] cap_crc = 8'hff;
  bit cap_km = 0;
  always @(negedge clk) if (rst_n && !done) begin
    check("R3", in_ready, m_busy == 0);
    check("R5", crc_valid, m_cv);
    if (m_cv) begin check("R1", crc_out, m_crc); cap_crc = crc_out; end
    check("R8", chk_valid, m_kv);
    if (m_kv) begin check("R8", chk_match, m_km); cap_km = chk_match; end
  end

  task automatic send(logic [7:0] d, bit sof, bit eof, bit ce);
    in_data = d; in_sof = sof; in_eof = eof; chk_en = ce; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; chk_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog [%s] actual 1 expected 0", phase);
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R2";
    check("R2", crc_out, 8'h00);
    check("R3", in_ready, 1);

    phase = "R4";
    len_mode = 2'b00;
    for (int n = 1; n <= 5; n += 2)
      for (int k = 0; k < n; k++) send($urandom, k == 0, k == n - 1, 0);
    len_mode = 2'b11;
    send(8'h5a, 1, 0, 0); send(8'h3c, 0, 1, 0);
    repeat (10) @(negedge clk);

    phase = "R10";
    len_mode = 2'b10; cap_crc = 8'hff;
    for (int k = 0; k < 7; k++) send(8'h00, k == 0, 0, 0);
    repeat (10) @(negedge clk);
    check("R10", cap_crc, 8'h00);

    phase = "R6";
    len_mode = 2'b01;
    send(8'h11, 0, 1, 0); send(8'h22, 0, 1, 0); send(8'h33, 0, 0, 0);
    repeat (10) @(negedge clk);

    phase = "R7";
    len_mode = 2'b10;
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 7; k++) send($urandom, k == 0, k == 2, 0);
    repeat (10) @(negedge clk);

    phase = "R1";
    len_mode = 2'b01;
    send(8'ha0, 1, 0, 0); send(8'h01, 0, 0, 0); send(8'h02, 0, 0, 0);
    repeat (10) @(negedge clk);

    phase = "R9";
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 3; k++) send($urandom, k == 0, 0, 0);
    repeat (10) @(negedge clk);

    phase = "R8";
    send(8'ha0, 1, 0, 0); send(8'h02, 0, 0, 0); send(8'h0c, 0, 0, 1);
    while (!crc_valid) @(negedge clk);
    rx = crc_out;
    send(rx, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R8", cap_km, 1);
    send(8'h77, 1, 0, 0); send(8'h10, 0, 0, 0); send(8'hfe, 0, 0, 1);
    while (!crc_valid) @(negedge clk);
    rx = crc_out ^ 8'h01;
    send(rx, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R8", cap_km, 0);
    send(8'h01, 1, 0, 0); send(8'h02, 0, 0, 0); send(8'h03, 0, 0, 0);
    repeat (10) @(negedge clk);

    finish_run();
  end
endmodule